// File: doc/BRIEF.md
# Serial Interrupt Acknowledge Chain

This block arbitrates among a fixed row of interrupt-capable devices that share one request line to a processor. Each device keeps a pending flag, which is set by a one-cycle pulse on its raise input. While any flag is set, the shared request output is high.

The processor answers by holding the acknowledge input high. That acknowledge enters at stage 0, which has the highest priority, and travels toward the last stage. A stage with nothing pending lets the acknowledge pass. The first stage that is pending stops it and wins. Only the winning stage places its vector on the data output, and the vector is present in the same cycle as the acknowledge.

When the processor lowers acknowledge, the winner's pending flag is cleared. The next acknowledge therefore reaches the next pending device in priority order.

Top module: `irq_ack_chain`

## Requirements
- R1: A pulse on `raise_i[k]` sets pending flag k at the next clock edge. `irq_o` is high exactly while at least one pending flag is set.
- R2: While `ack_i` is low, `pass_o`, `grant_o` and `vec_o` are all zero and `vec_valid_o` is low, whatever flags are pending.
- R3: While `ack_i` is high, `pass_o[k]` is 1 exactly when no stage with index 0..k is pending. A stage with nothing pending copies its incoming acknowledge to its outgoing one; a pending stage blocks it.
- R4: While `ack_i` is high, `grant_o` is one-hot on the lowest-index pending stage, and `vec_valid_o` is high. `vec_o` carries that stage's entry from `VEC_TABLE`, bits [k*VEC_W +: VEC_W]. With the default table, stages 0..3 give 0x40, 0x44, 0x48 and 0x4C. All of this appears in the same cycle as `ack_i`.
- R5: When `ack_i` is high and nothing is pending, `grant_o` is zero, `vec_valid_o` is low, `vec_o` reads 0 and `pass_o` is all ones.
- R6: At the first clock edge where `ack_i` is sampled low after being high, the pending flag of the last winner is cleared and the other flags are kept. Repeated acknowledges therefore serve all pending stages in index order.
- R7: If `raise_i[k]` arrives at the same edge that clears stage k, stage k stays pending.
- R8: An active-low asynchronous reset clears every pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_i | input | STAGES | Per-stage request pulse |
| ack_i | input | 1 | Acknowledge from the processor into stage 0 |
| irq_o | output | 1 | Shared request line to the processor |
| vec_o | output | VEC_W | Vector of the winning stage, zero if none |
| vec_valid_o | output | 1 | A stage has won the acknowledge |
| grant_o | output | STAGES | One-hot winning stage |
| pass_o | output | STAGES | Outgoing acknowledge of each stage |

## Verification
`pass_o`, `grant_o`, `vec_o` and `vec_valid_o` are combinational from `ack_i` and the pending flags, so they are due in the same cycle as the acknowledge. `irq_o` follows a raise pulse one edge later. The clearing of a winner lands on the first edge that samples the acknowledge low. The bench drives inputs on the falling edge and samples 1 ns later. Each check therefore falls either in the cycle of the acknowledge or after exactly the one rising edge that a registered result needs. Vector-table cases cover many request patterns from reset, and directed sequences cover draining in order, same-edge raise and clear, and the idle state.

// File: rtl/irq_ack_chain.sv
module irq_ack_chain #(
  parameter int STAGES = 4,
  parameter int VEC_W  = 8,
  parameter logic [STAGES*VEC_W-1:0] VEC_TABLE = {8'h4C, 8'h48, 8'h44, 8'h40}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] raise_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o,
  output logic [STAGES-1:0] grant_o,
  output logic [STAGES-1:0] pass_o
);

  logic [STAGES-1:0] pend;
  logic [STAGES-1:0] win_q;
  logic              ack_q;
  logic [STAGES-1:0] clr;

  // acknowledge ripples from stage 0 (highest priority) downward
  always_comb begin
    logic tok;
    tok = ack_i;
    for (int k = 0; k < STAGES; k++) begin
      grant_o[k] = tok & pend[k];
      tok        = tok & ~pend[k];
      pass_o[k]  = tok;
    end
  end

  always_comb begin
    vec_o = '0;
    for (int k = 0; k < STAGES; k++)
      if (grant_o[k]) vec_o = vec_o | VEC_TABLE[k*VEC_W +: VEC_W];
  end

  assign vec_valid_o = |grant_o;
  assign irq_o       = |pend;
  assign clr         = (ack_q && !ack_i) ? win_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      win_q <= '0;
      ack_q <= 1'b0;
    end else begin
      pend  <= (pend & ~clr) | raise_i;
      ack_q <= ack_i;
      if (ack_i) win_q <= grant_o;
    end
  end

endmodule

// File: rtl/irq_ack_chain_chk.sv
module irq_ack_chain_chk #(
  parameter int STAGES = 4,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAGES-1:0] raise_i,
  input logic              ack_i,
  input logic              irq_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic              vec_valid_o,
  input logic [STAGES-1:0] grant_o,
  input logic [STAGES-1:0] pass_o,
  input logic [STAGES-1:0] pend
);

  a_r1_raise_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i != '0) |=> irq_o);

  a_r2_idle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |-> (pass_o == '0 && grant_o == '0));

  a_r4_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  a_r4_ack_finds_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |-> vec_valid_o);

  a_r5_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> (vec_o == '0));

  a_r6_winner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_i && $past(ack_i) && ((raise_i & $past(grant_o)) == '0))
    |=> ((pend & $past(grant_o, 2)) == '0));

endmodule

bind irq_ack_chain irq_ack_chain_chk #(.STAGES(STAGES), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .ack_i(ack_i), .irq_o(irq_o),
  .vec_o(vec_o), .vec_valid_o(vec_valid_o), .grant_o(grant_o),
  .pass_o(pass_o), .pend(pend)
);

// File: tb/irq_ack_chain_tb.sv
module irq_ack_chain_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] raise_i = '0;
  logic       ack_i = 1'b0;
  logic       irq_o, vec_valid_o;
  logic [7:0] vec_o;
  logic [3:0] grant_o, pass_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_ack_chain dut_i (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .ack_i(ack_i), .irq_o(irq_o),
    .vec_o(vec_o), .vec_valid_o(vec_valid_o), .grant_o(grant_o), .pass_o(pass_o)
  );

  // {raise mask, expected grant, expected vector, expected pass}
  localparam logic [19:0] VECS [8] = '{
    {4'b0000, 4'b0000, 8'h00, 4'b1111},
    {4'b0001, 4'b0001, 8'h40, 4'b0000},
    {4'b0010, 4'b0010, 8'h44, 4'b0001},
    {4'b1000, 4'b1000, 8'h4C, 4'b0111},
    {4'b1010, 4'b0010, 8'h44, 4'b0001},
    {4'b1100, 4'b0100, 8'h48, 4'b0011},
    {4'b1111, 4'b0001, 8'h40, 4'b0000},
    {4'b0110, 4'b0010, 8'h44, 4'b0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; raise_i = '0; ack_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic raise(input logic [3:0] m);
    @(negedge clk); raise_i = m;
    @(negedge clk); raise_i = '0;
    #1;
  endtask

  // ack for one cycle, check grant/vec, then drop ack and let the clear edge pass
  task automatic ack_cycle(input string req, input logic [3:0] g, input logic [7:0] v);
    @(negedge clk); ack_i = 1'b1; #1;
    chk(req, {28'd0, grant_o}, {28'd0, g});
    chk(req, {24'd0, vec_o}, {24'd0, v});
    chk(req, {31'd0, vec_valid_o}, {31'd0, (g != 0)});
    @(negedge clk); ack_i = 1'b0;
    @(negedge clk); #1;
  endtask

  initial begin
    do_reset();
    #1;
    chk("R8 reset irq", {31'd0, irq_o}, 32'd0);
    chk("R2 reset pass", {28'd0, pass_o}, 32'd0);
    chk("R2 reset vec", {24'd0, vec_o}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      logic [3:0] m, g, p; logic [7:0] v;
      {m, g, v, p} = VECS[i];
      do_reset();
      raise(m);
      chk("R1 irq after raise", {31'd0, irq_o}, {31'd0, (m != 0)});
      @(negedge clk); ack_i = 1'b1; #1;
      chk("R3 pass", {28'd0, pass_o}, {28'd0, p});
      chk("R4 grant", {28'd0, grant_o}, {28'd0, g});
      chk("R4 R5 vec", {24'd0, vec_o}, {24'd0, v});
      @(negedge clk); ack_i = 1'b0;
      @(negedge clk); #1;
      chk("R6 residual irq", {31'd0, irq_o}, {31'd0, ((m & ~g) != 0)});
    end

    // R2: pending but no ack
    do_reset();
    raise(4'b0101);
    chk("R2 pass idle", {28'd0, pass_o}, 32'd0);
    chk("R2 grant idle", {28'd0, grant_o}, 32'd0);
    chk("R2 vec idle", {23'd0, vec_valid_o, vec_o}, 32'd0);

    // R6: drain all in order
    do_reset();
    raise(4'b1111);
    ack_cycle("R6 drain 0", 4'b0001, 8'h40);
    ack_cycle("R6 drain 1", 4'b0010, 8'h44);
    ack_cycle("R6 drain 2", 4'b0100, 8'h48);
    ack_cycle("R6 drain 3", 4'b1000, 8'h4C);
    chk("R1 irq low after drain", {31'd0, irq_o}, 32'd0);
    ack_cycle("R5 empty ack", 4'b0000, 8'h00);

    // R7: raise at the clearing edge
    do_reset();
    raise(4'b0011);
    @(negedge clk); ack_i = 1'b1; #1;
    chk("R7 first grant", {28'd0, grant_o}, 32'd1);
    @(negedge clk); ack_i = 1'b0; raise_i = 4'b0001;
    @(negedge clk); raise_i = '0; #1;
    ack_cycle("R7 stage kept", 4'b0001, 8'h40);
    ack_cycle("R7 then next", 4'b0010, 8'h44);

    // R1: higher-priority raise mid-stream takes the next ack
    do_reset();
    raise(4'b1000);
    raise(4'b0100);
    ack_cycle("R1 R4 later raise", 4'b0100, 8'h48);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule